// File: doc/BRIEF.md
# Match-Wait Microprogram Sequencer

This block steps through a program of 16-bit instructions held in an external program store. Each cycle it presents a 7-bit program counter, takes the addressed instruction back on a combinational return path, and executes it. Most instructions take one cycle. The wait instruction holds the counter for a bounded window while it watches an active-low match input. When a match arrives, execution falls through to the next instruction. When the window runs out, execution jumps to a target address. Two flag outputs report how the most recent wait ended.

The move instructions place data on a 16-bit bus or take data from it. The data can be one 16-bit slice of either of two 48-bit address registers (a destination and a source), one word of an internal 128-word scratch memory, or one word exchanged with an external FIFO port. The bus is split into an input, an output and an output enable, so the bidirectional pad can sit outside the block. Every move instruction also sets two active-low control outputs from two bits in its own encoding, for that cycle only.

Top module: `mws_sequencer`

## Requirements
- R1: While `rst_n` is low, `pcOut` is 0 and both `matchFound` and `matchFail` are 0. Both flags also return to 0 when reset is applied after a wait has set one of them.
- R2: Every instruction other than a wait advances `pcOut` by one at the clock edge that ends its cycle. The counter goes from 127 to 0.
- R3: Opcodes 0000, 0001 and 1xxx in bits 15:12 are no-ops. The counter advances by one, `busOe`, `fifoRd` and `fifoWr` stay 0, and `ctlAN` and `ctlBN` stay 1.
- R4: A wait instruction has opcode 0010, the count y in bits 11:8, bit 7 low, and the target in bits 6:0. Its window lasts y+4 cycles, counting its first cycle as cycle 1. If `matchN` is low at the edge ending any cycle of the window, including the first and the last, then `pcOut` becomes the wait's address plus one and `matchFound` becomes 1.
- R5: If `matchN` stays high for all y+4 cycles of the window, `pcOut` holds the wait's address through those cycles. At the edge ending cycle y+4, `pcOut` becomes the target and `matchFail` becomes 1.
- R6: Both flags are cleared at the edge ending the first cycle of a wait that has not yet matched. At most one flag is ever set. The flag that is set keeps its value through later non-wait instructions.
- R7: Opcode 0011 drives `busOut` with a slice chosen by bits 7:4. Codes 0, 1 and 2 select destination bits 15:0, 31:16 and 47:32. Codes 3, 4 and 5 select the same ranges of the source register. Any other code drives 0.
- R8: Opcode 0101 writes `busIn` into scratch word bits 10:4 at the edge ending its cycle. Opcode 0100 drives `busOut` with the scratch word at bits 10:4 during its cycle.
- R9: Opcode 0110 drives `busOut` with `fifoRdData` and raises `fifoRd` for exactly that cycle. Opcode 0111 raises `fifoWr` for exactly that cycle, with `fifoWrData` equal to `busIn`.
- R10: `busOe` is 1 only during opcodes 0011, 0100 and 0110.
- R11: During any move instruction (opcodes 0011 to 0111), `ctlAN` equals instruction bit 2 and `ctlBN` equals bit 1. At all other times both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pcOut | output | 7 | Program counter, addresses the external program store |
| instrIn | input | 16 | Instruction returned by the program store for `pcOut` |
| matchN | input | 1 | Match indication, active low |
| matchFound | output | 1 | The last wait ended on a match |
| matchFail | output | 1 | The last wait timed out |
| destAddr | input | 48 | Destination address register value |
| srcAddr | input | 48 | Source address register value |
| busIn | input | 16 | Value read from the data bus |
| busOut | output | 16 | Value driven onto the data bus |
| busOe | output | 1 | Enables the bus driver |
| fifoRdData | input | 16 | Head entry of the external FIFO |
| fifoRd | output | 1 | Pops the FIFO head, one cycle |
| fifoWrData | output | 16 | Word pushed into the FIFO |
| fifoWr | output | 1 | Pushes into the FIFO, one cycle |
| ctlAN | output | 1 | First control strobe, active low |
| ctlBN | output | 1 | Second control strobe, active low |

## Verification
A corrupted wait counter shows up on `pcOut`. The counter either leaves the wait address one or more cycles away from y+4, or jumps to the target when it should have fallen through. The check at the edge that ends the window catches this within one instruction. A wrong flag register appears on `matchFound` or `matchFail` at the edge after the wait ends, or while a later non-wait instruction runs. A bad scratch write stays hidden until a later read of the same word drives `busOut`, so the random program writes and reads back across several passes of the 128-entry counter.

// File: rtl/mws_pkg.sv
package mws_pkg;
  localparam logic [3:0] OP_WAIT   = 4'b0010;
  localparam logic [3:0] OP_SLICE  = 4'b0011;
  localparam logic [3:0] OP_MEMRD  = 4'b0100;
  localparam logic [3:0] OP_MEMWR  = 4'b0101;
  localparam logic [3:0] OP_FIFORD = 4'b0110;
  localparam logic [3:0] OP_FIFOWR = 4'b0111;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_SLICE,
    SRC_MEM,
    SRC_FIFO
  } busSrc_e;

  typedef struct packed {
    busSrc_e busSrc;
    logic    busOe;
    logic    memWe;
    logic    fifoRd;
    logic    fifoWr;
    logic    moveCyc;
    logic    ctlA;
    logic    ctlB;
  } strobes_t;
endpackage

// File: rtl/mws_ctrl.sv
module mws_ctrl
  import mws_pkg::*;
#(
  parameter int PC_W  = 7,
  parameter int Y_W   = 4,
  parameter int INS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INS_W-1:0] instr,
  input  logic             matchN,
  output logic [PC_W-1:0]  pc,
  output logic             found,
  output logic             fail,
  output strobes_t         stb
);
  localparam int CNT_W = Y_W + 1;

  logic [3:0]       op;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             unusedInstr;

  assign op          = instr[INS_W-1 -: 4];
  assign limit       = CNT_W'(instr[8 +: Y_W]) + CNT_W'(4);
  assign unusedInstr = ^{instr[7], instr[3], instr[0]};

  // Program counter, wait window counter and outcome flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      cnt   <= '0;
      found <= 1'b0;
      fail  <= 1'b0;
    end else if (op == OP_WAIT) begin
      if (!matchN) begin
        found <= 1'b1;
        fail  <= 1'b0;
        cnt   <= '0;
        pc    <= pc + 1'b1;
      end else if (cnt + 1'b1 == limit) begin
        found <= 1'b0;
        fail  <= 1'b1;
        cnt   <= '0;
        pc    <= instr[PC_W-1:0];
      end else begin
        found <= 1'b0;
        fail  <= 1'b0;
        cnt   <= cnt + 1'b1;
      end
    end else begin
      pc <= pc + 1'b1;
    end
  end

  // Decode into datapath strobes
  always_comb begin
    stb        = '0;
    stb.busSrc = SRC_NONE;
    case (op)
      OP_SLICE: begin
        stb.busSrc = SRC_SLICE;
        stb.busOe  = 1'b1;
      end
      OP_MEMRD: begin
        stb.busSrc = SRC_MEM;
        stb.busOe  = 1'b1;
      end
      OP_MEMWR:  stb.memWe = 1'b1;
      OP_FIFORD: begin
        stb.busSrc = SRC_FIFO;
        stb.busOe  = 1'b1;
        stb.fifoRd = 1'b1;
      end
      OP_FIFOWR: stb.fifoWr = 1'b1;
      default: ;
    endcase
    stb.moveCyc = (op >= OP_SLICE) && (op <= OP_FIFOWR);
    stb.ctlA    = instr[2];
    stb.ctlB    = instr[1];
  end
endmodule

// File: rtl/mws_datapath.sv
module mws_datapath
  import mws_pkg::*;
#(
  parameter int ADDR_REG_W = 48,
  parameter int SLICE_W    = 16,
  parameter int MEM_DEPTH  = 128,
  parameter int SEL_W      = 4
) (
  input  logic                         clk,
  input  strobes_t                     stb,
  input  logic [SEL_W-1:0]             sliceSel,
  input  logic [$clog2(MEM_DEPTH)-1:0] memAddr,
  input  logic [ADDR_REG_W-1:0]        destAddr,
  input  logic [ADDR_REG_W-1:0]        srcAddr,
  input  logic [SLICE_W-1:0]           busIn,
  input  logic [SLICE_W-1:0]           fifoRdData,
  output logic [SLICE_W-1:0]           busOut
);
  localparam int NUM_SLICES = ADDR_REG_W / SLICE_W;
  localparam int NUM_SEL    = 2 * NUM_SLICES;

  logic [SLICE_W-1:0] sliceArr [NUM_SEL];
  logic [SLICE_W-1:0] sliceVal;
  logic [SLICE_W-1:0] mem [MEM_DEPTH];

  // Destination slices first, then source slices
  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    assign sliceArr[g]              = destAddr[g*SLICE_W +: SLICE_W];
    assign sliceArr[g + NUM_SLICES] = srcAddr[g*SLICE_W +: SLICE_W];
  end

  always_comb begin
    sliceVal = '0;
    for (int s = 0; s < NUM_SEL; s++) begin
      if (sliceSel == SEL_W'(s)) sliceVal = sliceArr[s];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.memWe) mem[memAddr] <= busIn;
  end

  always_comb begin
    case (stb.busSrc)
      SRC_SLICE: busOut = sliceVal;
      SRC_MEM:   busOut = mem[memAddr];
      SRC_FIFO:  busOut = fifoRdData;
      default:   busOut = '0;
    endcase
  end
endmodule

// File: rtl/mws_sequencer.sv
module mws_sequencer
  import mws_pkg::*;
#(
  parameter int PC_W       = 7,
  parameter int INS_W      = 16,
  parameter int ADDR_REG_W = 48,
  parameter int SLICE_W    = 16,
  parameter int MEM_DEPTH  = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [PC_W-1:0]       pcOut,
  input  logic [INS_W-1:0]      instrIn,
  input  logic                  matchN,
  output logic                  matchFound,
  output logic                  matchFail,
  input  logic [ADDR_REG_W-1:0] destAddr,
  input  logic [ADDR_REG_W-1:0] srcAddr,
  input  logic [SLICE_W-1:0]    busIn,
  output logic [SLICE_W-1:0]    busOut,
  output logic                  busOe,
  input  logic [SLICE_W-1:0]    fifoRdData,
  output logic                  fifoRd,
  output logic [SLICE_W-1:0]    fifoWrData,
  output logic                  fifoWr,
  output logic                  ctlAN,
  output logic                  ctlBN
);
  localparam int MEM_AW = $clog2(MEM_DEPTH);

  strobes_t stb;

  mws_ctrl #(.PC_W(PC_W), .Y_W(4), .INS_W(INS_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .instr(instrIn), .matchN(matchN),
    .pc(pcOut), .found(matchFound), .fail(matchFail), .stb(stb)
  );

  mws_datapath #(
    .ADDR_REG_W(ADDR_REG_W), .SLICE_W(SLICE_W), .MEM_DEPTH(MEM_DEPTH), .SEL_W(4)
  ) dp_i (
    .clk(clk), .stb(stb), .sliceSel(instrIn[7:4]), .memAddr(instrIn[4 +: MEM_AW]),
    .destAddr(destAddr), .srcAddr(srcAddr), .busIn(busIn),
    .fifoRdData(fifoRdData), .busOut(busOut)
  );

  assign busOe      = stb.busOe;
  assign fifoRd     = stb.fifoRd;
  assign fifoWr     = stb.fifoWr;
  assign fifoWrData = busIn;
  assign ctlAN      = stb.moveCyc ? stb.ctlA : 1'b1;
  assign ctlBN      = stb.moveCyc ? stb.ctlB : 1'b1;
endmodule

// File: rtl/mws_sequencer_chk.sv
module mws_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [6:0]  pcOut,
  input logic [15:0] instrIn,
  input logic        matchFound,
  input logic        matchFail,
  input logic [15:0] busIn,
  input logic [15:0] busOut,
  input logic        busOe,
  input logic [15:0] fifoRdData,
  input logic        fifoRd,
  input logic [15:0] fifoWrData,
  input logic        fifoWr,
  input logic        ctlAN,
  input logic        ctlBN
);
  logic notMove;
  assign notMove = (instrIn[15:12] < 4'd3) || (instrIn[15:12] > 4'd7);

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(matchFound && matchFail));

  p_found_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matchFound) |-> pcOut == 7'($past(pcOut) + 7'd1));

  p_fail_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matchFail) |-> pcOut == $past(instrIn[6:0]));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (instrIn[15:12] != 4'b0010) |=> pcOut == 7'($past(pcOut) + 7'd1));

  p_fifo_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifoRd |-> busOe && busOut == fifoRdData && !fifoWr);

  p_fifo_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifoWr |-> fifoWrData == busIn);

  p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (notMove || fifoWr) |-> !busOe);

  p_ctl_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    notMove |-> ctlAN && ctlBN);
endmodule

bind mws_sequencer mws_sequencer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pcOut(pcOut), .instrIn(instrIn),
  .matchFound(matchFound), .matchFail(matchFail), .busIn(busIn),
  .busOut(busOut), .busOe(busOe), .fifoRdData(fifoRdData), .fifoRd(fifoRd),
  .fifoWrData(fifoWrData), .fifoWr(fifoWr), .ctlAN(ctlAN), .ctlBN(ctlBN)
);

// File: tb/mws_sequencer_tb.sv
`timescale 1ns/1ps
module mws_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] prog [128];
  logic [6:0]  pcOut;
  logic [15:0] instrIn;
  logic        matchN = 1'b1;
  logic        matchFound, matchFail;
  logic [47:0] destAddr = '0, srcAddr = '0;
  logic [15:0] busIn = '0, busOut, fifoRdData = '0, fifoWrData;
  logic        busOe, fifoRd, fifoWr, ctlAN, ctlBN;

  int checks = 0;
  int errors = 0;
  logic [15:0] mdl [128];
  bit          mdlOk [128];
  logic [6:0]  expPc;

  always #2.5 clk = ~clk;
  assign instrIn = prog[pcOut];

  mws_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .pcOut(pcOut), .instrIn(instrIn), .matchN(matchN),
    .matchFound(matchFound), .matchFail(matchFail), .destAddr(destAddr),
    .srcAddr(srcAddr), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .fifoRdData(fifoRdData), .fifoRd(fifoRd), .fifoWrData(fifoWrData),
    .fifoWr(fifoWr), .ctlAN(ctlAN), .ctlBN(ctlBN)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] encWait(input logic [3:0] y, input logic [6:0] t);
    return {4'b0010, y, 1'b0, t};
  endfunction

  function automatic logic [15:0] encMove(input logic [3:0] op, input logic [6:0] mid,
                                          input logic c, input logic e);
    return {op, 1'b0, mid, op[0], c, e, 1'b1};
  endfunction

  function automatic logic [15:0] randInstr();
    logic [15:0] r;
    logic c, e;
    r = 16'($urandom);
    c = r[0];
    e = r[1];
    case ($urandom_range(0, 6))
      0: return encMove(4'b0011, {3'b000, 4'($urandom_range(0, 7))}, c, e);
      1: return encMove(4'b0100, r[8:2], c, e);
      2: return encMove(4'b0101, r[8:2], c, e);
      3: return encMove(4'b0110, 7'd0, c, e);
      4: return encMove(4'b0111, 7'd0, c, e);
      5: return {3'b000, r[12:0]};
      default: return {1'b1, r[14:0]};
    endcase
  endfunction

  function automatic logic [15:0] expSlice(input logic [3:0] sel);
    if (sel < 4'd3) return destAddr[sel*16 +: 16];
    if (sel < 4'd6) return srcAddr[(sel-3)*16 +: 16];
    return 16'h0000;
  endfunction

  // One wait-window cycle: drive matchN, then check registered results
  task automatic waitStep(input logic mN, input logic [6:0] pcE, input logic fE,
                          input logic flE, input string req);
    matchN = mN;
    @(negedge clk);
    matchN = 1'b1;
    chk(req, "pc", pcOut, pcE);
    chk(req, "found", matchFound, fE);
    chk(req, "fail", matchFail, flE);
  endtask

  // One instruction of the move/no-op program, checked against the model
  task automatic progStep();
    logic [15:0] ins, bIn;
    logic [3:0]  op;
    logic [6:0]  a;
    bit          mv, oe;
    bIn = 16'($urandom);
    busIn = bIn;
    fifoRdData = 16'($urandom);
    #0.5;
    ins = prog[expPc];
    op  = ins[15:12];
    a   = ins[10:4];
    mv  = (op >= 4'd3) && (op <= 4'd7);
    oe  = (op == 4'd3) || (op == 4'd4) || (op == 4'd6);
    chk("R2", "pc", pcOut, expPc);
    chk(mv ? "R10" : "R3", "busOe", busOe, oe);
    if (op == 4'd3) chk("R7", "slice", busOut, expSlice(ins[7:4]));
    if (op == 4'd4 && mdlOk[a]) chk("R8", "memrd", busOut, mdl[a]);
    if (op == 4'd6) chk("R9", "fifo data", busOut, fifoRdData);
    chk(mv ? "R9" : "R3", "fifoRd", fifoRd, op == 4'd6);
    chk(mv ? "R9" : "R3", "fifoWr", fifoWr, op == 4'd7);
    if (op == 4'd7) chk("R9", "fifoWrData", fifoWrData, bIn);
    chk(mv ? "R11" : "R3", "ctlAN", ctlAN, mv ? ins[2] : 1'b1);
    chk(mv ? "R11" : "R3", "ctlBN", ctlBN, mv ? ins[1] : 1'b1);
    @(negedge clk);
    if (op == 4'd5) begin
      mdl[a]   = bIn;
      mdlOk[a] = 1'b1;
    end
    expPc = expPc + 7'd1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd715));
    for (int i = 0; i < 128; i++) begin
      prog[i]  = 16'h0000;
      mdlOk[i] = 1'b0;
    end
    // Reset state (R1)
    repeat (3) @(negedge clk);
    chk("R1", "pc", pcOut, 7'd0);
    chk("R1", "found", matchFound, 1'b0);
    chk("R1", "fail", matchFail, 1'b0);

    // Wait instructions (R4, R5, R6)
    prog[0]    = encWait(4'd0, 7'd5);
    prog[6]    = encWait(4'd1, 7'h20);
    prog[7]    = encWait(4'd15, 7'd9);
    prog[8]    = encWait(4'd15, 7'h30);
    prog[7'h30] = encWait(4'd0, 7'h10);
    rst_n = 1'b1;
    for (int k = 1; k < 4; k++) waitStep(1'b1, 7'd0, 1'b0, 1'b0, "R5");
    waitStep(1'b1, 7'd5, 1'b0, 1'b1, "R5");
    chk("R10", "oe after wait", busOe, 1'b0);
    chk("R11", "ctlAN idle", ctlAN, 1'b1);
    waitStep(1'b1, 7'd6, 1'b0, 1'b1, "R6");
    waitStep(1'b1, 7'd6, 1'b0, 1'b0, "R6");
    waitStep(1'b0, 7'd7, 1'b1, 1'b0, "R4");
    waitStep(1'b0, 7'd8, 1'b1, 1'b0, "R4");
    for (int k = 1; k < 19; k++) waitStep(1'b1, 7'd8, 1'b0, 1'b0, "R5");
    waitStep(1'b1, 7'h30, 1'b0, 1'b1, "R5");
    for (int k = 1; k < 4; k++) waitStep(1'b1, 7'h30, 1'b0, 1'b0, "R4");
    waitStep(1'b0, 7'h31, 1'b1, 1'b0, "R4");

    // Reset clears flags (R1)
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "pc after reset", pcOut, 7'd0);
    chk("R1", "found after reset", matchFound, 1'b0);

    // No-op program and counter wrap (R2, R3)
    for (int i = 0; i < 128; i++)
      prog[i] = (i % 2 == 0) ? {4'b0001, 12'($urandom)} : {1'b1, 15'($urandom)};
    rst_n = 1'b1;
    expPc = 7'd0;
    for (int i = 0; i < 128; i++) progStep();
    chk("R2", "wrap", pcOut, 7'd0);

    // Random move program with directed corners (R7..R11)
    rst_n = 1'b0;
    for (int i = 0; i < 128; i++) prog[i] = randInstr();
    prog[0] = encMove(4'b0101, 7'd127, 1'b0, 1'b1);
    prog[1] = encMove(4'b0100, 7'd127, 1'b1, 1'b0);
    prog[2] = encMove(4'b0011, 7'd5, 1'b0, 1'b0);
    prog[3] = encMove(4'b0011, 7'd6, 1'b1, 1'b1);
    prog[4] = encMove(4'b0110, 7'd0, 1'b0, 1'b1);
    prog[5] = encMove(4'b0111, 7'd0, 1'b1, 1'b0);
    destAddr = {16'($urandom), 32'($urandom)};
    srcAddr  = {16'($urandom), 32'($urandom)};
    @(negedge clk);
    rst_n = 1'b1;
    expPc = 7'd0;
    for (int i = 0; i < 400; i++) progStep();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule